// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Adapter

This adapter connects a peripheral that moves byte streams to a 32-bit memory port. The peripheral presents one transfer at a time: a start address, a byte length, a direction and a swap flag. The adapter combines the start address with a base register value using a bitwise OR, not an addition, and issues memory commands. It carries the data beats between the two sides, four bytes per beat in stream order.

In swap mode the address and the length are first rounded down to even values. The two bytes of every halfword are exchanged in both directions. Memory writes are broken into bursts that never exceed a configured size. When swap mode is off, address, length and data pass through untouched. Every interface uses valid/ready handshakes, so backpressure on either side stalls the adapter and no beat is lost. The requester learns that a transfer has finished from a single-cycle done pulse.

Top module: `dma_hw_swap`

## Requirements
- R1: The memory command address is `req_addr_i | base_i`, taken when the request is accepted. It is a bitwise OR, never a sum. With swap off, a transfer is issued as a single command whose length equals `req_len_i`.
- R2: In swap mode, bit 0 of the ORed address and bit 0 of the length are cleared before any command is issued. A swap request of length 1 therefore becomes a zero-length transfer.
- R3: For a swap-mode write, each beat sent to memory swaps bytes within each halfword: bits [7:0] exchange with [15:8], and bits [23:16] exchange with [31:24].
- R4: For a swap-mode read, each beat returned to the peripheral carries the same halfword byte exchange as in R3.
- R5: With swap off, write beats and read beats pass through unchanged, in order.
- R6: A swap-mode write is split into consecutive commands of min(remaining, 64) bytes. Each command address is the previous address plus the previous length. Each command carries ceil(len/4) data beats, and `mem_wlast_o` is high on the last of them only.
- R7: A read is always issued as a single command of the full length, in swap mode as well, after the R2 rounding.
- R8: `done_o` is high for exactly one cycle. That cycle follows the handshake of the final data beat. `req_ready_o` is high in the cycle after the pulse.
- R9: A zero-length request, including one made zero by R2, issues no memory command. It raises `done_o` in the cycle after acceptance.
- R10: While `mem_cmd_valid_o` is high and `mem_cmd_ready_i` is low, the command fields hold steady. Data beats are neither dropped nor duplicated under any pattern of ready and valid stalls.
- R11: During reset, `req_ready_o` is 1 and `done_o`, `mem_cmd_valid_o`, `mem_wvalid_o` and `pr_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | 32 | Base value ORed into the address |
| req_valid_i | input | 1 | Transfer request valid |
| req_ready_o | output | 1 | Adapter idle, request can be accepted |
| req_addr_i | input | 32 | Peripheral byte address |
| req_len_i | input | 16 | Transfer length in bytes |
| req_write_i | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| req_swap_i | input | 1 | Enable halfword swap mode |
| done_o | output | 1 | Single-cycle completion pulse |
| pw_valid_i | input | 1 | Peripheral write beat valid |
| pw_ready_o | output | 1 | Peripheral write beat accepted |
| pw_data_i | input | 32 | Peripheral write beat |
| pr_valid_o | output | 1 | Read beat to peripheral valid |
| pr_ready_i | input | 1 | Peripheral accepts read beat |
| pr_data_o | output | 32 | Read beat to peripheral |
| mem_cmd_valid_o | output | 1 | Memory command valid |
| mem_cmd_ready_i | input | 1 | Memory accepts command |
| mem_cmd_addr_o | output | 32 | Command byte address |
| mem_cmd_len_o | output | 16 | Command length in bytes |
| mem_cmd_write_o | output | 1 | Command direction |
| mem_wvalid_o | output | 1 | Write beat valid |
| mem_wready_i | input | 1 | Memory accepts write beat |
| mem_wdata_o | output | 32 | Write beat |
| mem_wlast_o | output | 1 | Final beat of the current command |
| mem_rvalid_i | input | 1 | Read beat valid from memory |
| mem_rready_o | output | 1 | Adapter accepts read beat |
| mem_rdata_i | input | 32 | Read beat from memory |

## Verification
The assertions assume the following about the inputs:
- Memory returns exactly ceil(len/4) read beats for each read command, and sends no read beat before its command is accepted.
- The peripheral supplies exactly as many write beats as the transfer needs.

The stimulus meets these rules by generating read beats only when a read command is accepted, and write beats only when a request is accepted. Both counts come from the rounded length. Valid and ready are stalled at random on every channel, and a source never withdraws a valid beat before it is taken. Requests are presented only while no transfer is in flight.

// File: rtl/dma_hw_swap_pkg.sv
package dma_hw_swap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_WDATA = 3'd2,
    ST_RDATA = 3'd3,
    ST_DONE  = 3'd4
  } xfer_state_e;
endpackage

// File: rtl/hw_swap_lanes.sv
module hw_swap_lanes #(
  parameter int BEAT_BYTES = 4
) (
  input  logic                    en_i,
  input  logic [8*BEAT_BYTES-1:0] data_i,
  output logic [8*BEAT_BYTES-1:0] data_o
);
  localparam int HALVES = BEAT_BYTES / 2;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign data_o[16*h +: 8]   = en_i ? data_i[16*h+8 +: 8] : data_i[16*h +: 8];
    assign data_o[16*h+8 +: 8] = en_i ? data_i[16*h +: 8]   : data_i[16*h+8 +: 8];
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int BURST_BYTES = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  input  logic          swap_i,
  input  logic          split_i,
  input  logic          advance_i,
  output logic          load_zero_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [LW-1:0] burst_len_o,
  output logic          last_burst_o
);
  localparam logic [LW-1:0] BURST_LEN = LW'(BURST_BYTES);

  logic [AW-1:0] addr_q, addr_eff;
  logic [LW-1:0] rem_q, len_eff;
  logic          split_q;

  // OR, then force halfword alignment in swap mode
  always_comb begin
    addr_eff = addr_i | base_i;
    len_eff  = len_i;
    if (swap_i) begin
      addr_eff[0] = 1'b0;
      len_eff[0]  = 1'b0;
    end
  end

  assign load_zero_o  = (len_eff == '0);
  assign burst_len_o  = (split_q && (rem_q > BURST_LEN)) ? BURST_LEN : rem_q;
  assign last_burst_o = (rem_q == burst_len_o);
  assign cur_addr_o   = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      rem_q   <= '0;
      split_q <= 1'b0;
    end else if (load_i) begin
      addr_q  <= addr_eff;
      rem_q   <= len_eff;
      split_q <= split_i;
    end else if (advance_i) begin
      addr_q <= addr_q + AW'(burst_len_o);
      rem_q  <= rem_q - burst_len_o;
    end
  end

  a_r6_rem_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/dma_beat_ctr.sv
module dma_beat_ctr #(
  parameter int LW         = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [LW-1:0] bytes_i,
  output logic          last_o
);
  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);

  logic [LW:0] beats, cnt_q;

  assign beats  = ({1'b0, bytes_i} + (LW+1)'(BEAT_BYTES - 1)) >> BEAT_SHIFT;
  assign last_o = ((cnt_q + 1'b1) == beats);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  a_r10_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (cnt_q < beats));
endmodule

// File: rtl/dma_hw_swap.sv
module dma_hw_swap
  import dma_hw_swap_pkg::*;
#(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int BEAT_BYTES  = 4,
  parameter int BURST_BYTES = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           base_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [AW-1:0]           req_addr_i,
  input  logic [LW-1:0]           req_len_i,
  input  logic                    req_write_i,
  input  logic                    req_swap_i,
  output logic                    done_o,
  input  logic                    pw_valid_i,
  output logic                    pw_ready_o,
  input  logic [8*BEAT_BYTES-1:0] pw_data_i,
  output logic                    pr_valid_o,
  input  logic                    pr_ready_i,
  output logic [8*BEAT_BYTES-1:0] pr_data_o,
  output logic                    mem_cmd_valid_o,
  input  logic                    mem_cmd_ready_i,
  output logic [AW-1:0]           mem_cmd_addr_o,
  output logic [LW-1:0]           mem_cmd_len_o,
  output logic                    mem_cmd_write_o,
  output logic                    mem_wvalid_o,
  input  logic                    mem_wready_i,
  output logic [8*BEAT_BYTES-1:0] mem_wdata_o,
  output logic                    mem_wlast_o,
  input  logic                    mem_rvalid_i,
  output logic                    mem_rready_o,
  input  logic [8*BEAT_BYTES-1:0] mem_rdata_i
);
  localparam logic [LW-1:0] BURST_LEN = LW'(BURST_BYTES);

  xfer_state_e state_q, state_d;
  logic write_q, swap_q;
  logic req_fire, cmd_fire, w_fire, r_fire;
  logic load_zero, beat_last, last_burst, advance;
  logic [LW-1:0] burst_len;

  assign req_ready_o = (state_q == ST_IDLE);
  assign req_fire    = req_valid_i && req_ready_o;

  assign mem_cmd_valid_o = (state_q == ST_CMD);
  assign mem_cmd_write_o = write_q;
  assign mem_cmd_len_o   = burst_len;
  assign cmd_fire        = mem_cmd_valid_o && mem_cmd_ready_i;

  assign mem_wvalid_o = (state_q == ST_WDATA) && pw_valid_i;
  assign pw_ready_o   = (state_q == ST_WDATA) && mem_wready_i;
  assign mem_wlast_o  = (state_q == ST_WDATA) && beat_last;
  assign w_fire       = mem_wvalid_o && mem_wready_i;

  assign pr_valid_o   = (state_q == ST_RDATA) && mem_rvalid_i;
  assign mem_rready_o = (state_q == ST_RDATA) && pr_ready_i;
  assign r_fire       = pr_valid_o && pr_ready_i;

  assign advance = w_fire && beat_last;
  assign done_o  = (state_q == ST_DONE);

  dma_addr_gen #(
    .AW(AW), .LW(LW), .BURST_BYTES(BURST_BYTES)
  ) u_addr_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (req_fire),
    .addr_i       (req_addr_i),
    .base_i       (base_i),
    .len_i        (req_len_i),
    .swap_i       (req_swap_i),
    .split_i      (req_swap_i && req_write_i),
    .advance_i    (advance),
    .load_zero_o  (load_zero),
    .cur_addr_o   (mem_cmd_addr_o),
    .burst_len_o  (burst_len),
    .last_burst_o (last_burst)
  );

  dma_beat_ctr #(
    .LW(LW), .BEAT_BYTES(BEAT_BYTES)
  ) u_beat_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (cmd_fire),
    .step_i  (w_fire || r_fire),
    .bytes_i (burst_len),
    .last_o  (beat_last)
  );

  hw_swap_lanes #(.BEAT_BYTES(BEAT_BYTES)) u_swap_wr (
    .en_i (swap_q), .data_i (pw_data_i), .data_o (mem_wdata_o)
  );

  hw_swap_lanes #(.BEAT_BYTES(BEAT_BYTES)) u_swap_rd (
    .en_i (swap_q), .data_i (mem_rdata_i), .data_o (pr_data_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_fire) state_d = load_zero ? ST_DONE : ST_CMD;
      ST_CMD:   if (cmd_fire) state_d = write_q ? ST_WDATA : ST_RDATA;
      ST_WDATA: if (advance)  state_d = last_burst ? ST_DONE : ST_CMD;
      ST_RDATA: if (r_fire && beat_last) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      swap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (req_fire) begin
        write_q <= req_write_i;
        swap_q  <= req_swap_i;
      end
    end
  end

  a_r10_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cmd_valid_o && !mem_cmd_ready_i) |=>
      (mem_cmd_valid_o && $stable(mem_cmd_addr_o) && $stable(mem_cmd_len_o)));

  a_r6_burst_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cmd_valid_o && mem_cmd_write_o && swap_q) |->
      ((mem_cmd_len_o <= BURST_LEN) && (mem_cmd_len_o != '0)));

  a_r2_even_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cmd_valid_o && swap_q) |-> (!mem_cmd_addr_o[0] && !mem_cmd_len_o[0]));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));

  a_r9_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (req_len_i == '0)) |=> (done_o && !mem_cmd_valid_o));
endmodule

// File: tb/dma_hw_swap_bench.sv
module dma_hw_swap_bench;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int DW = 32;

  typedef struct {
    logic [AW-1:0] addr;
    logic [LW-1:0] len;
    bit            wr;
  } cmd_t;

  typedef struct {
    logic [AW-1:0] addr;
    logic [AW-1:0] base;
    logic [LW-1:0] len;
    bit            wr;
    bit            swap;
    string         tag;
  } job_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] base_i = '0, req_addr_i = '0;
  logic [LW-1:0] req_len_i = '0;
  logic req_valid_i = 0, req_write_i = 0, req_swap_i = 0;
  logic pw_valid_i = 0, pr_ready_i = 0, mem_cmd_ready_i = 0;
  logic mem_wready_i = 0, mem_rvalid_i = 0;
  logic [DW-1:0] pw_data_i = '0, mem_rdata_i = '0;
  logic req_ready_o, done_o, pw_ready_o, pr_valid_o;
  logic mem_cmd_valid_o, mem_cmd_write_o, mem_wvalid_o, mem_wlast_o, mem_rready_o;
  logic [DW-1:0] pr_data_o, mem_wdata_o;
  logic [AW-1:0] mem_cmd_addr_o;
  logic [LW-1:0] mem_cmd_len_o;

  dma_hw_swap u_dma_hw_swap (
    .clk_i(clk), .rst_ni(rst_ni), .base_i(base_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i),
    .req_write_i(req_write_i), .req_swap_i(req_swap_i), .done_o(done_o),
    .pw_valid_i(pw_valid_i), .pw_ready_o(pw_ready_o), .pw_data_i(pw_data_i),
    .pr_valid_o(pr_valid_o), .pr_ready_i(pr_ready_i), .pr_data_o(pr_data_o),
    .mem_cmd_valid_o(mem_cmd_valid_o), .mem_cmd_ready_i(mem_cmd_ready_i),
    .mem_cmd_addr_o(mem_cmd_addr_o), .mem_cmd_len_o(mem_cmd_len_o),
    .mem_cmd_write_o(mem_cmd_write_o),
    .mem_wvalid_o(mem_wvalid_o), .mem_wready_i(mem_wready_i),
    .mem_wdata_o(mem_wdata_o), .mem_wlast_o(mem_wlast_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rready_o(mem_rready_o),
    .mem_rdata_i(mem_rdata_i)
  );

  int n_tests = 0;
  int n_fail  = 0;

  job_t          jobs[$];
  cmd_t          exp_cmd[$];
  logic [DW-1:0] src_q[$], exp_w[$], rd_supply[$], exp_r[$];
  bit            exp_wlast[$];
  bit            busy = 0, done_due = 0, cur_swap = 0;
  string         cur_tag = "";
  int            beats_left = 0;
  bit            prev_stall = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [LW-1:0] prev_len = '0;

  function automatic logic [DW-1:0] hswap(logic [DW-1:0] d);
    return {d[23:16], d[31:24], d[7:0], d[15:8]};
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic add_job(logic [AW-1:0] a, logic [AW-1:0] b, int l, bit wr, bit sw, string tag);
    job_t j;
    j.addr = a; j.base = b; j.len = LW'(l); j.wr = wr; j.swap = sw; j.tag = tag;
    jobs.push_back(j);
  endtask

  // reference model: build expected commands and beats at request acceptance
  task automatic model_request(job_t j);
    logic [AW-1:0] a;
    logic [LW-1:0] rem, c;
    int nb;
    cmd_t cm;
    a = j.addr | j.base;
    rem = j.len;
    if (j.swap) begin a[0] = 1'b0; rem[0] = 1'b0; end
    cur_swap = j.swap;
    cur_tag  = j.tag;
    beats_left = 0;
    if (rem == 0) begin
      done_due = 1;
      return;
    end
    while (rem != 0) begin
      c = (j.wr && j.swap && rem > 64) ? LW'(64) : rem;
      cm.addr = a; cm.len = c; cm.wr = j.wr;
      exp_cmd.push_back(cm);
      nb = (int'(c) + 3) / 4;
      beats_left += nb;
      if (j.wr) begin
        for (int i = 0; i < nb; i++) begin
          logic [DW-1:0] d;
          d = $urandom;
          src_q.push_back(d);
          exp_w.push_back(j.swap ? hswap(d) : d);
          exp_wlast.push_back(i == nb - 1);
        end
      end
      a += AW'(c);
      rem -= c;
    end
  endtask

  // sample before the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      if (done_o || done_due)
        check(done_o == done_due, {cur_tag, " R8 done timing"}, done_o, done_due);
      if (done_o) busy = 0;
      done_due = 0;

      if (prev_stall)
        check(mem_cmd_valid_o && mem_cmd_addr_o == prev_addr && mem_cmd_len_o == prev_len,
              "R10 command held under stall", mem_cmd_addr_o, prev_addr);

      if (req_valid_i && req_ready_o) begin
        job_t j;
        j = jobs.pop_front();
        busy = 1;
        model_request(j);
      end

      if (mem_cmd_valid_o && mem_cmd_ready_i) begin
        if (exp_cmd.size() == 0) begin
          check(0, {cur_tag, " R9 unexpected command"}, mem_cmd_addr_o, 0);
        end else begin
          cmd_t e;
          e = exp_cmd.pop_front();
          check(mem_cmd_addr_o == e.addr, {cur_tag, " R1 command address"}, mem_cmd_addr_o, e.addr);
          check(mem_cmd_len_o == e.len, {cur_tag, " R6 command length"}, mem_cmd_len_o, e.len);
          check(mem_cmd_write_o == e.wr, {cur_tag, " R7 command direction"}, mem_cmd_write_o, e.wr);
          if (!e.wr) begin
            for (int i = 0; i < (int'(e.len) + 3) / 4; i++) begin
              logic [DW-1:0] d;
              d = $urandom;
              rd_supply.push_back(d);
              exp_r.push_back(cur_swap ? hswap(d) : d);
            end
          end
        end
      end

      if ((pw_valid_i && pw_ready_o) || (mem_wvalid_o && mem_wready_i))
        check((pw_valid_i && pw_ready_o) == (mem_wvalid_o && mem_wready_i),
              "R10 write beat pairing", pw_ready_o, mem_wready_i);
      if (pw_valid_i && pw_ready_o && src_q.size() > 0) void'(src_q.pop_front());

      if (mem_wvalid_o && mem_wready_i) begin
        if (exp_w.size() == 0) begin
          check(0, {cur_tag, " R10 extra write beat"}, mem_wdata_o, 0);
        end else begin
          logic [DW-1:0] e;
          bit el;
          e = exp_w.pop_front();
          el = exp_wlast.pop_front();
          check(mem_wdata_o == e, {cur_tag, cur_swap ? " R3 write swap" : " R5 write pass"}, mem_wdata_o, e);
          check(mem_wlast_o == el, {cur_tag, " R6 wlast"}, mem_wlast_o, el);
          beats_left--;
          if (beats_left == 0) done_due = 1;
        end
      end

      if (mem_rvalid_i && mem_rready_o && rd_supply.size() > 0) void'(rd_supply.pop_front());
      if (pr_valid_o && pr_ready_i) begin
        if (exp_r.size() == 0) begin
          check(0, {cur_tag, " R10 extra read beat"}, pr_data_o, 0);
        end else begin
          logic [DW-1:0] e;
          e = exp_r.pop_front();
          check(pr_data_o == e, {cur_tag, cur_swap ? " R4 read swap" : " R5 read pass"}, pr_data_o, e);
          beats_left--;
          if (beats_left == 0) done_due = 1;
        end
      end

      prev_stall = mem_cmd_valid_o && !mem_cmd_ready_i;
      prev_addr  = mem_cmd_addr_o;
      prev_len   = mem_cmd_len_o;
    end
  end

  // drive after the active edge
  always @(posedge clk) begin
    #1;
    if (rst_ni) begin
      req_valid_i = (jobs.size() > 0) && !busy;
      if (jobs.size() > 0) begin
        base_i = jobs[0].base; req_addr_i = jobs[0].addr; req_len_i = jobs[0].len;
        req_write_i = jobs[0].wr; req_swap_i = jobs[0].swap;
      end
      if (src_q.size() > 0) begin
        pw_data_i = src_q[0];
        if (!pw_valid_i) pw_valid_i = ($urandom % 4) != 0;
      end else pw_valid_i = 0;
      if (rd_supply.size() > 0) begin
        mem_rdata_i = rd_supply[0];
        if (!mem_rvalid_i) mem_rvalid_i = ($urandom % 4) != 0;
      end else mem_rvalid_i = 0;
      mem_cmd_ready_i = ($urandom % 3) != 0;
      mem_wready_i    = ($urandom % 3) != 0;
      pr_ready_i      = ($urandom % 3) != 0;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    check(req_ready_o == 1, "R11 reset ready", req_ready_o, 1);
    check(done_o == 0, "R11 reset done", done_o, 0);
    check(mem_cmd_valid_o == 0 && mem_wvalid_o == 0 && pr_valid_o == 0,
          "R11 reset valids", {mem_cmd_valid_o, mem_wvalid_o, pr_valid_o}, 0);
    rst_ni = 1;

    add_job(32'h0000_1000, 32'h0003_0000, 12, 1, 0, "R1 R5 plain write");
    add_job(32'h0000_000F, 32'h0000_000F, 8, 1, 0, "R1 or-not-add");
    add_job(32'h0000_1001, 32'h8000_0000, 7, 1, 1, "R2 R3 odd swap write");
    add_job(32'h0000_2000, 32'h0000_0000, 200, 1, 1, "R6 split write");
    add_job(32'h0000_3000, 32'h0000_0000, 64, 1, 1, "R6 exact burst");
    add_job(32'h0000_3100, 32'h0000_0000, 128, 1, 1, "R6 two bursts");
    add_job(32'h0000_4003, 32'h0001_0000, 130, 0, 1, "R4 R7 swap read");
    add_job(32'h0000_5000, 32'h0000_0040, 9, 0, 0, "R5 R7 plain read");
    add_job(32'h0000_6000, 32'h0000_0000, 100, 1, 0, "R1 unsplit write");
    add_job(32'h0000_7000, 32'h0000_0000, 0, 1, 0, "R9 zero write");
    add_job(32'h0000_7000, 32'h0000_0000, 0, 0, 1, "R9 zero read");
    add_job(32'h0000_7001, 32'h0000_0000, 1, 1, 1, "R2 R9 swap len one");
    add_job(32'h0000_8002, 32'h0000_0100, 6, 0, 1, "R4 short swap read");

    cyc = 0;
    while ((jobs.size() > 0 || busy || done_due) && cyc < 100000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 100000) begin
      n_tests++; n_fail++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 100000);
    end
    @(negedge clk);
    check(exp_cmd.size() == 0 && exp_w.size() == 0 && exp_r.size() == 0,
          "R6 all expected traffic seen", exp_cmd.size() + exp_w.size() + exp_r.size(), 0);
    check(req_ready_o == 1, "R8 idle at end", req_ready_o, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule